// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block works through a circular list of transmit descriptors held in a word-wide synchronous memory. Each descriptor is two 32-bit words. The first word holds the control and status flags and a negated byte count. The second word holds the buffer address. The sequencer looks for the first buffer of a frame and chains buffers until it reaches the one marked last. For every buffer it hands one fetch request to a downstream data mover. When it has finished with a descriptor it writes the first word back, with ownership handed back to the host and any error flags filled in.

Underflow is reported abstractly by a FIFO-empty input. A recovery control selects between two reactions to a truncated frame. The block can stop the transmitter, which it shows by dropping a transmit-on output. Or it can step forward through the ring, passing over continuation buffers, until it finds the next frame start. When no frame is ready the block re-reads the same slot after a parameterised wait. A demand input cuts that wait short.

Layout of word 0, as read and written by the block: bit 31 owned by block, bit 30 first buffer of frame, bit 29 last buffer of frame, bit 28 parity error, bit 27 buffer error, bit 26 underflow, bits 25..12 carried through untouched (bits 15..12 expected to be ones), bits 11..0 negated byte count. Descriptor n sits at word addresses 2n (word 0) and 2n+1 (address).

Top module: `tx_ring_seq`

## Requirements
- R1: A frame starts only at a descriptor whose bits 31 and 30 are both 1. A descriptor with bit 31 set and bit 30 clear, met outside a frame, is passed over: no fetch is issued for it and its words stay unchanged.
- R2: On reading a descriptor with bit 31 clear, the block reads that same word 0 again POLL_CYCLES+2 cycles later. A pulse on pollNow during the wait makes the re-read happen on the next cycle.
- R3: Each fetch request is a single-cycle fetchValid pulse. It carries the word-1 address, a length equal to the 12-bit two's-complement negation of bits 11..0 (a field of 0 gives length 0), and bits 30 and 29 as the first and last markers.
- R4: A buffer with bit 29 clear is followed by the next ring descriptor in the same frame. A buffer with bit 29 set ends the frame. A descriptor with both bits 30 and 29 set produces exactly one request.
- R5: Each descriptor that was fetched gets exactly one write of word 0. That write has bit 31 cleared, bits 30, 29 and 25..0 as read, and bits 28..26 holding the outcome flags. Reads and writes never share a cycle.
- R6: After a buffer without bit 29, if the next descriptor has bit 31 clear, or fifoEmpty is 1 while that descriptor's word 0 is being read, the current descriptor is written with bits 27 and 26 both set and the frame is aborted.
- R7: fifoEmpty at 1 while a fetch is outstanding sets bit 26 on that descriptor, truncates the frame, and pulses frameAbort in the writeback cycle.
- R8: With recoverEn at 0, an abort drops txOn and stops all memory and fetch activity until reset.
- R9: With recoverEn at 1, after an abort the scan goes on at the next descriptor, passing over continuation descriptors until a frame start is found.
- R10: A parErr pulse during a fetch sets bit 28 on that descriptor only when parityEn is 1.
- R11: The ring index steps from RING_LEN-1 back to 0, both when scanning and inside a chained frame.
- R12: After reset txOn is 1, and the first operation is a read of word 0 of descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| recoverEn | input | 1 | 1: resynchronise after underflow; 0: halt |
| parityEn | input | 1 | Allows the parity flag to be recorded |
| pollNow | input | 1 | Demand pulse that ends a poll wait early |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 32 | Writeback word |
| memRdata | input | 32 | Read data, one cycle after memRe |
| fetchValid | output | 1 | Fetch request pulse |
| fetchAddr | output | 32 | Buffer address of the request |
| fetchLen | output | 12 | Byte length of the request |
| fetchSof | output | 1 | Request is the first buffer of a frame |
| fetchEof | output | 1 | Request is the last buffer of a frame |
| fetchDone | input | 1 | Data mover finished the outstanding buffer |
| fifoEmpty | input | 1 | Transmit FIFO ran dry |
| parErr | input | 1 | Parity error pulse for the outstanding buffer |
| frameAbort | output | 1 | Pulse: current frame truncated |
| txOn | output | 1 | Transmitter running |

## Verification
A reference walk of the ring predicts the exact list of fetch requests, the final memory image, the abort count and the final txOn level. Random rings mixing owned, unowned, start, middle and end descriptors, with random byte counts, test chaining against skipping and wrap-around. Directed rings isolate single-buffer frames with a zero count, a three-buffer chain, leading continuation descriptors, a chain that ends at an unowned descriptor, FIFO-empty during a transfer and during the look-ahead read, parity with the enable off and on, and a frame that spans the wrap. Underflow cases run in both recovery modes: halting shows up as fewer requests and a low txOn, and recovery shows up as skipped continuation buffers. A separate timing case measures the poll period and shows that the demand pulse shortens it.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_B  = 31;
  localparam int SOF_B  = 30;
  localparam int EOF_B  = 29;
  localparam int PERR_B = 28;
  localparam int BUFF_B = 27;
  localparam int UFLO_B = 26;
  localparam int CNT_W  = 12;

  typedef enum logic [1:0] {
    SEL_CUR0 = 2'd0,
    SEL_CUR1 = 2'd1,
    SEL_NXT0 = 2'd2
  } memSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    ldCur;
    logic    ldAddr;
    logic    ldLook;
    logic    chain;
    logic    advance;
    logic    clrFlags;
    logic    setUflo;
    logic    setBuff;
    logic    setPerr;
    memSel_e sel;
  } dpCtl_t;
endpackage

// File: rtl/txr_dp.sv
module txr_dp
  import txr_pkg::*;
#(
  parameter int RING_LEN = 8,
  localparam int IDX_W  = (RING_LEN > 1) ? $clog2(RING_LEN) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       fetchAddr,
  output logic [CNT_W-1:0]  fetchLen,
  output logic              fetchSof,
  output logic              fetchEof,
  output logic              rdOwn,
  output logic              rdSof,
  output logic              curEof
);
  logic [IDX_W-1:0] idx, nxtIdx;
  logic [31:0] curW0, lookW0, curAddr;
  logic perrF, buffF, ufloF;

  always_comb nxtIdx = (idx == IDX_W'(RING_LEN - 1)) ? '0 : idx + 1'b1;

  always_comb begin
    case (ctl.sel)
      SEL_CUR0: memAddr = {idx, 1'b0};
      SEL_CUR1: memAddr = {idx, 1'b1};
      default:  memAddr = {nxtIdx, 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      curW0   <= '0;
      lookW0  <= '0;
      curAddr <= '0;
    end else begin
      if (ctl.advance) idx <= nxtIdx;
      if (ctl.ldCur) curW0 <= memRdata;
      else if (ctl.chain) curW0 <= lookW0;
      if (ctl.ldLook) lookW0 <= memRdata;
      if (ctl.ldAddr) curAddr <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perrF <= 1'b0;
      buffF <= 1'b0;
      ufloF <= 1'b0;
    end else if (ctl.clrFlags) begin
      perrF <= 1'b0;
      buffF <= 1'b0;
      ufloF <= 1'b0;
    end else begin
      if (ctl.setPerr) perrF <= 1'b1;
      if (ctl.setBuff) buffF <= 1'b1;
      if (ctl.setUflo) ufloF <= 1'b1;
    end
  end

  always_comb begin
    memWdata         = curW0;
    memWdata[OWN_B]  = 1'b0;
    memWdata[PERR_B] = perrF;
    memWdata[BUFF_B] = buffF;
    memWdata[UFLO_B] = ufloF;
  end

  assign fetchAddr = curAddr;
  assign fetchLen  = CNT_W'(0) - curW0[CNT_W-1:0];
  assign fetchSof  = curW0[SOF_B];
  assign fetchEof  = curW0[EOF_B];
  assign curEof    = curW0[EOF_B];
  assign rdOwn     = memRdata[OWN_B];
  assign rdSof     = memRdata[SOF_B];

  // R6
  buff_uflo_chk: assert property (@(posedge clk) disable iff (!rstN) buffF |-> ufloF);
  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN) idx <= IDX_W'(RING_LEN - 1));
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int POLL_CYCLES = 64,
  localparam int PW = $clog2(POLL_CYCLES + 1)
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   recoverEn,
  input  logic   parityEn,
  input  logic   pollNow,
  input  logic   fetchDone,
  input  logic   fifoEmpty,
  input  logic   parErr,
  input  logic   rdOwn,
  input  logic   rdSof,
  input  logic   curEof,
  output dpCtl_t ctl,
  output logic   memRe,
  output logic   memWe,
  output logic   fetchValid,
  output logic   frameAbort,
  output logic   txOn
);
  typedef enum logic [3:0] {
    S_RD0, S_CHK, S_POLL, S_RDA, S_CAPA, S_ISSUE,
    S_XFER, S_LOOK0, S_LOOK1, S_WB, S_HALT
  } state_e;
  typedef enum logic [1:0] {O_END, O_CHAIN, O_ABORT} outc_e;

  state_e st, nxt;
  outc_e  outc, outNxt;
  logic [PW-1:0] pollCnt;
  logic pollLd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_RD0;
      outc    <= O_END;
      pollCnt <= '0;
    end else begin
      st   <= nxt;
      outc <= outNxt;
      if (pollLd) pollCnt <= PW'(POLL_CYCLES - 1);
      else if (st == S_POLL && pollCnt != '0) pollCnt <= pollCnt - 1'b1;
    end
  end

  always_comb begin
    nxt        = st;
    outNxt     = outc;
    ctl        = '0;
    ctl.sel    = SEL_CUR0;
    memRe      = 1'b0;
    memWe      = 1'b0;
    fetchValid = 1'b0;
    frameAbort = 1'b0;
    pollLd     = 1'b0;
    case (st)
      S_RD0: begin
        memRe = 1'b1;
        nxt   = S_CHK;
      end
      S_CHK: begin
        ctl.ldCur = 1'b1;
        if (rdOwn && rdSof) nxt = S_RDA;
        else if (rdOwn) begin
          ctl.advance = 1'b1;
          nxt = S_RD0;
        end else begin
          pollLd = 1'b1;
          nxt = S_POLL;
        end
      end
      S_POLL: if (pollNow || pollCnt == '0) nxt = S_RD0;
      S_RDA: begin
        memRe   = 1'b1;
        ctl.sel = SEL_CUR1;
        nxt     = S_CAPA;
      end
      S_CAPA: begin
        ctl.ldAddr = 1'b1;
        nxt = S_ISSUE;
      end
      S_ISSUE: begin
        fetchValid = 1'b1;
        nxt = S_XFER;
      end
      S_XFER: begin
        if (parErr && parityEn) ctl.setPerr = 1'b1;
        if (fifoEmpty) begin
          ctl.setUflo = 1'b1;
          outNxt = O_ABORT;
          nxt = S_WB;
        end else if (fetchDone) begin
          if (curEof) begin
            outNxt = O_END;
            nxt = S_WB;
          end else nxt = S_LOOK0;
        end
      end
      S_LOOK0: begin
        memRe   = 1'b1;
        ctl.sel = SEL_NXT0;
        if (fifoEmpty) begin
          ctl.setUflo = 1'b1;
          ctl.setBuff = 1'b1;
          outNxt = O_ABORT;
          nxt = S_WB;
        end else nxt = S_LOOK1;
      end
      S_LOOK1: begin
        if (fifoEmpty || !rdOwn) begin
          ctl.setUflo = 1'b1;
          ctl.setBuff = 1'b1;
          outNxt = O_ABORT;
        end else begin
          ctl.ldLook = 1'b1;
          outNxt = O_CHAIN;
        end
        nxt = S_WB;
      end
      S_WB: begin
        memWe = 1'b1;
        ctl.clrFlags = 1'b1;
        case (outc)
          O_CHAIN: begin
            ctl.advance = 1'b1;
            ctl.chain = 1'b1;
            nxt = S_RDA;
          end
          O_ABORT: begin
            frameAbort = 1'b1;
            if (recoverEn) begin
              ctl.advance = 1'b1;
              nxt = S_RD0;
            end else nxt = S_HALT;
          end
          default: begin
            ctl.advance = 1'b1;
            nxt = S_RD0;
          end
        endcase
      end
      default: nxt = S_HALT;
    endcase
  end

  assign txOn = (st != S_HALT);

  // R5
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memRe && memWe));
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txOn |=> (!txOn && !memRe && !memWe && !fetchValid));
  // R3
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) fetchValid |=> !fetchValid);
  // R7
  abort_wb_chk: assert property (@(posedge clk) disable iff (!rstN) frameAbort |-> memWe);
endmodule

// File: rtl/tx_ring_seq.sv
module tx_ring_seq
  import txr_pkg::*;
#(
  parameter int RING_LEN    = 8,
  parameter int POLL_CYCLES = 64,
  localparam int IDX_W  = (RING_LEN > 1) ? $clog2(RING_LEN) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recoverEn,
  input  logic              parityEn,
  input  logic              pollNow,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              fetchValid,
  output logic [31:0]       fetchAddr,
  output logic [11:0]       fetchLen,
  output logic              fetchSof,
  output logic              fetchEof,
  input  logic              fetchDone,
  input  logic              fifoEmpty,
  input  logic              parErr,
  output logic              frameAbort,
  output logic              txOn
);
  dpCtl_t ctl;
  logic rdOwn, rdSof, curEof;

  txr_ctrl #(.POLL_CYCLES(POLL_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .recoverEn(recoverEn), .parityEn(parityEn),
    .pollNow(pollNow), .fetchDone(fetchDone), .fifoEmpty(fifoEmpty),
    .parErr(parErr), .rdOwn(rdOwn), .rdSof(rdSof), .curEof(curEof),
    .ctl(ctl), .memRe(memRe), .memWe(memWe), .fetchValid(fetchValid),
    .frameAbort(frameAbort), .txOn(txOn)
  );

  txr_dp #(.RING_LEN(RING_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .fetchAddr(fetchAddr),
    .fetchLen(fetchLen), .fetchSof(fetchSof), .fetchEof(fetchEof),
    .rdOwn(rdOwn), .rdSof(rdSof), .curEof(curEof)
  );
endmodule

// File: tb/tx_ring_seq_bench.sv
module tx_ring_seq_bench;
  localparam int RL = 8;
  localparam int POLL = 40;
  localparam int MW = 2 * RL;
  localparam int AW = $clog2(RL) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recoverEn = 1'b0, parityEn = 1'b0, pollNow = 1'b0;
  logic memRe, memWe, fetchValid, fetchSof, fetchEof, frameAbort, txOn;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, fetchAddr;
  logic [31:0] memRdata = '0;
  logic [11:0] fetchLen;
  logic fetchDone = 1'b0, fifoEmpty = 1'b0, parErr = 1'b0;

  always #5 clk = ~clk;

  tx_ring_seq #(.RING_LEN(RL), .POLL_CYCLES(POLL)) u_tx_ring_seq (
    .clk(clk), .rstN(rstN), .recoverEn(recoverEn), .parityEn(parityEn),
    .pollNow(pollNow), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .fetchLen(fetchLen), .fetchSof(fetchSof),
    .fetchEof(fetchEof), .fetchDone(fetchDone), .fifoEmpty(fifoEmpty),
    .parErr(parErr), .frameAbort(frameAbort), .txOn(txOn)
  );

  logic [31:0] mem [0:MW-1];
  logic [31:0] em  [0:MW-1];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0;

  // observed and expected request lists
  logic [31:0] gotAddr [0:63];
  logic [11:0] gotLen  [0:63];
  logic        gotSof  [0:63];
  logic        gotEof  [0:63];
  logic [31:0] expAddr [0:63];
  logic [11:0] expLen  [0:63];
  logic        expSof  [0:63];
  logic        expEof  [0:63];
  int gotN, gotAborts, expN, expAborts;
  bit expHalt;

  // data mover scenario knobs
  int uReq = -1, lookReq = -1, pReq = -1;
  int curReq, cnt;
  bit lookPend, parPend;
  int firstFetchCyc;

  always @(negedge clk) begin
    cyc++;
    fetchDone = 1'b0;
    fifoEmpty = 1'b0;
    parErr = 1'b0;
    if (!rstN) begin
      cnt = 0; lookPend = 0; parPend = 0; curReq = 0;
      gotN = 0; gotAborts = 0; firstFetchCyc = -1;
    end else begin
      if (lookPend) begin fifoEmpty = 1'b1; lookPend = 0; end
      if (parPend) begin parErr = 1'b1; parPend = 0; end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          if (curReq == uReq) fifoEmpty = 1'b1;
          else begin
            fetchDone = 1'b1;
            if (curReq == lookReq) lookPend = 1;
          end
        end
      end
      if (frameAbort) gotAborts++;
      if (fetchValid) begin
        if (firstFetchCyc < 0) firstFetchCyc = cyc;
        if (gotN < 64) begin
          gotAddr[gotN] = fetchAddr; gotLen[gotN] = fetchLen;
          gotSof[gotN] = fetchSof;   gotEof[gotN] = fetchEof;
        end
        curReq = gotN;
        gotN++;
        cnt = 1 + int'($urandom_range(3));
        parPend = (curReq == pReq);
      end
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkW0(bit own, bit sof, bit eof, int len);
    logic [11:0] c;
    c = 12'(0 - len);
    return {own, sof, eof, 13'd0, 4'hF, c};
  endfunction

  task automatic setDesc(int i, bit own, bit sof, bit eof, int len);
    mem[2*i]   = mkW0(own, sof, eof, len);
    mem[2*i+1] = 32'h1000_0000 + 32'(i * 32'h100) + 32'(len);
  endtask

  task automatic clearRing();
    for (int i = 0; i < RL; i++) setDesc(i, 0, 0, 0, 0);
  endtask

  task automatic holdReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // reference walk of the ring built from the requirements
  task automatic buildModel(bit rec, bit pen);
    int idx, r, guard, nx;
    bit done, inFrame, chainIt, abortIt;
    logic [31:0] w;
    for (int k = 0; k < MW; k++) em[k] = mem[k];
    idx = 0; r = 0; guard = 0; done = 0;
    expN = 0; expAborts = 0; expHalt = 0;
    while (!done && guard < 300) begin
      guard++;
      w = em[2*idx];
      if (!w[31]) done = 1;                       // R2: poll here forever
      else if (!w[30]) idx = (idx + 1) % RL;      // R1: skip
      else begin
        inFrame = 1;
        while (inFrame && guard < 300) begin
          guard++;
          expAddr[expN] = em[2*idx+1];
          expLen[expN]  = 12'(0 - w[11:0]);       // R3
          expSof[expN]  = w[30];
          expEof[expN]  = w[29];
          expN++;
          chainIt = 0; abortIt = 0;
          nx = (idx + 1) % RL;                    // R11
          if (pen && r == pReq) w[28] = 1'b1;      // R10
          if (r == uReq) begin w[26] = 1'b1; abortIt = 1; end   // R7
          else if (!w[29]) begin
            if (r == lookReq || !em[2*nx][31]) begin  // R6
              w[27] = 1'b1; w[26] = 1'b1; abortIt = 1;
            end else chainIt = 1;                 // R4
          end
          w[31] = 1'b0;                           // R5
          em[2*idx] = w;
          r++;
          if (chainIt) begin
            idx = nx;
            w = em[2*idx];
          end else begin
            inFrame = 0;
            if (abortIt) begin
              expAborts++;
              if (rec) idx = nx;                  // R9
              else begin expHalt = 1; done = 1; end   // R8
            end else idx = nx;
          end
        end
      end
    end
  endtask

  task automatic runScenario(string tag, int u, int lk, int p, bit rec, bit pen, int cycles);
    int bad;
    uReq = u; lookReq = lk; pReq = p;
    recoverEn = rec; parityEn = pen;
    buildModel(rec, pen);
    @(negedge clk);
    rstN = 1'b1;
    repeat (cycles) @(negedge clk);
    chk(gotN == expN, $sformatf("R3 R4 %s request count", tag), gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      chk(gotAddr[i] == expAddr[i] && gotLen[i] == expLen[i] &&
          gotSof[i] == expSof[i] && gotEof[i] == expEof[i],
          $sformatf("R3 R4 %s request %0d addr/len/sof/eof", tag, i),
          {gotAddr[i], gotLen[i], 2'(gotSof[i]), 2'(gotEof[i])},
          {expAddr[i], expLen[i], 2'(expSof[i]), 2'(expEof[i])});
    end
    bad = -1;
    for (int k = MW - 1; k >= 0; k--) if (mem[k] !== em[k]) bad = k;
    chk(bad < 0, $sformatf("R5 %s memory image word %0d", tag, bad),
        (bad < 0) ? 0 : mem[bad], (bad < 0) ? 0 : em[bad]);
    chk(gotAborts == expAborts, $sformatf("R7 %s abort count", tag), gotAborts, expAborts);
    chk(txOn == !expHalt, $sformatf("R8 R9 %s txOn", tag), txOn, !expHalt);
  endtask

  initial begin
    int lastRead, gap, demandCyc, seen;
    void'($urandom(32'h5eed_1234));

    // R12 reset state and R2 polling with an empty ring
    holdReset();
    clearRing();
    uReq = -1; lookReq = -1; pReq = -1;
    @(negedge clk);
    rstN = 1'b1;
    chk(txOn == 1'b1, "R12 txOn after reset", txOn, 1);
    chk(memRe == 1'b1 && memAddr == '0 && !memWe && !fetchValid,
        "R12 first operation reads word 0 of slot 0", {memRe, memWe, fetchValid}, 3'b100);
    lastRead = cyc;
    gap = -1;
    seen = 0;
    for (int t = 0; t < 3 * (POLL + 2) && seen == 0; t++) begin
      @(negedge clk);
      if (memRe && memAddr == '0) begin gap = cyc - lastRead; seen = 1; end
    end
    chk(gap == POLL + 2, "R2 poll period", gap, POLL + 2);
    repeat (3) @(negedge clk);
    setDesc(0, 1, 1, 1, 9);
    pollNow = 1'b1;
    demandCyc = cyc;
    @(negedge clk);
    pollNow = 1'b0;
    repeat (10) @(negedge clk);
    chk(firstFetchCyc > 0 && firstFetchCyc - demandCyc <= 7,
        "R2 demand poll shortens wait", firstFetchCyc - demandCyc, 7);
    chk(gotN == 1 && gotLen[0] == 12'd9, "R3 demand frame length", gotLen[0], 9);

    // R4 R3 single-buffer frames, including zero length
    holdReset(); clearRing();
    setDesc(0, 1, 1, 1, 5); setDesc(1, 1, 1, 1, 0); setDesc(2, 1, 1, 1, 4095);
    runScenario("single", -1, -1, -1, 1, 0, 300);

    // R4 three-buffer chain
    holdReset(); clearRing();
    setDesc(0, 1, 1, 0, 10); setDesc(1, 1, 0, 0, 20); setDesc(2, 1, 0, 1, 30);
    runScenario("chain", -1, -1, -1, 1, 0, 300);

    // R1 leading owned descriptors without start are passed over untouched
    holdReset(); clearRing();
    setDesc(0, 1, 0, 0, 3); setDesc(1, 1, 0, 1, 4); setDesc(2, 1, 1, 1, 6);
    runScenario("R1 skip", -1, -1, -1, 1, 0, 300);
    chk(mem[0] == mkW0(1, 0, 0, 3) && mem[2] == mkW0(1, 0, 1, 4),
        "R1 skipped words unchanged", mem[0], mkW0(1, 0, 0, 3));

    // R6 chain runs into an unowned descriptor
    holdReset(); clearRing();
    setDesc(0, 1, 1, 0, 7); setDesc(1, 0, 0, 1, 7); setDesc(2, 1, 1, 1, 2);
    runScenario("R6 next unowned", -1, -1, -1, 1, 0, 400);
    chk(mem[0][27] && mem[0][26], "R6 buffer error implies underflow bits", mem[0][27:26], 2'b11);

    // R6 FIFO empties during the look-ahead read
    holdReset(); clearRing();
    setDesc(0, 1, 1, 0, 7); setDesc(1, 1, 0, 1, 8); setDesc(2, 1, 1, 1, 2);
    runScenario("R6 look-ahead empty", -1, 0, -1, 1, 0, 400);

    // R7 R8 underflow with halt
    holdReset(); clearRing();
    setDesc(0, 1, 1, 1, 12); setDesc(1, 1, 1, 1, 13);
    runScenario("R8 halt", 0, -1, -1, 0, 0, 400);

    // R7 R9 underflow with recovery over continuation buffers
    holdReset(); clearRing();
    setDesc(0, 1, 1, 0, 5); setDesc(1, 1, 0, 0, 6); setDesc(2, 1, 0, 1, 7);
    setDesc(3, 1, 1, 1, 8);
    runScenario("R9 recover", 1, -1, -1, 1, 0, 400);

    // R10 parity flag with enable off, then on
    holdReset(); clearRing();
    setDesc(0, 1, 1, 1, 4);
    runScenario("R10 parity off", -1, -1, 0, 1, 0, 200);
    chk(mem[0][28] == 1'b0, "R10 parity ignored when disabled", mem[0][28], 0);
    holdReset(); clearRing();
    setDesc(0, 1, 1, 1, 4);
    runScenario("R10 parity on", -1, -1, 0, 1, 1, 200);
    chk(mem[0][28] == 1'b1, "R10 parity recorded when enabled", mem[0][28], 1);

    // R11 frame spanning the wrap, slot 0 skipped first
    holdReset(); clearRing();
    setDesc(0, 1, 0, 1, 11);
    for (int i = 1; i < 6; i++) setDesc(i, 1, 1, 1, i);
    setDesc(6, 1, 1, 0, 16); setDesc(7, 1, 0, 0, 17);
    runScenario("R11 wrap", -1, -1, -1, 1, 0, 700);

    // random rings mixed with random underflow and parity placement
    for (int s = 0; s < 30; s++) begin
      bit anyFree;
      int u, lk, p;
      holdReset();
      anyFree = 0;
      for (int i = 0; i < RL; i++) begin
        bit o;
        o = ($urandom_range(9) < 7);
        setDesc(i, o, $urandom_range(1), $urandom_range(2) == 0, $urandom_range(40));
        if (!o) anyFree = 1;
      end
      if (!anyFree) setDesc(RL - 1, 0, 1, 1, 1);
      u  = ($urandom_range(2) == 0) ? int'($urandom_range(5)) : -1;
      lk = ($urandom_range(2) == 0) ? int'($urandom_range(5)) : -1;
      p  = ($urandom_range(1) == 0) ? int'($urandom_range(5)) : -1;
      runScenario($sformatf("R1 R9 random%0d", s), u, lk, p,
                  $urandom_range(1), $urandom_range(1), 900);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule